// File: doc/BRIEF.md
# In-Order Completion Queue Controller

This block keeps the program order of instructions between dispatch and retirement, so that a core whose execution units finish work out of order can still take precise exceptions. Fetched instructions enter a four-slot fetch buffer. The oldest buffered instruction is sent to dispatch only when a slot in a six-slot circular completion ring can be claimed for it in the same cycle. The index of that slot is the instruction's tag. Execution units later report the tag as finished, with or without a fault. The ring releases its oldest entry once that entry is finished and clean.

When the oldest entry is finished with a fault, the block does not retire it. It discards that entry, every younger ring entry and the whole fetch buffer, and raises a flush request that carries the faulting tag. The request holds until it is acknowledged. Only tags and queue bookkeeping are modelled. The block contains no opcode, operand or result data.

Top module: `ooo_completion_ctrl`

## Requirements
- R1: After reset, no dispatch, retirement or flush request is signalled, and `fetch_ready_o` is high.
- R2: The fetch buffer holds at most four instructions and accepts at most one per clock (`fetch_valid_i` and `fetch_ready_o` both high). `fetch_ready_o` is low while four are held.
- R3: Dispatch takes only the oldest buffered instruction, in first-in first-out order, at most one per clock. Its tag is the ring's allocation slot. Successive tags count up 0,1,2,3,4,5,0,…
- R4: The completion ring holds six entries. Dispatch is held off in any cycle that begins with six live entries.
- R5: A branch (`fetch_branch_i`=1) claims a ring entry like any other instruction. Its branch flag comes out on `disp_branch_o` and later on `retire_branch_o`.
- R6: At most one entry retires per clock. It is always the oldest live entry, and it retires only when it is marked finished with no fault. `retire_tag_o` follows dispatch order.
- R7: A finished report (`done_valid_i`) marks entry `done_tag_i` as finished, with its fault flag set to `done_exc_i`. The entry can retire at the earliest in the next cycle. A report naming a tag that is not live (including codes 6 and 7) has no effect.
- R8: When the oldest live entry is finished with a fault, it does not retire. In that cycle nothing dispatches and `fetch_ready_o` is low. All ring entries and the fetch buffer are emptied at the following edge. From the next cycle, `flush_req_o` is high with `flush_tag_o` equal to the faulting tag. It stays high until a cycle with `flush_ack_i` high. While it is high, nothing is fetched or dispatched.
- R9: After a flush, the next allocated tag is the faulting tag. Allocation continues upward from it.
- R10: Dispatch and retirement in the same cycle leave the occupancy unchanged. A ring that was full can therefore dispatch again in the cycle after such a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid_i | input | 1 | Instruction offered to the fetch buffer |
| fetch_branch_i | input | 1 | Offered instruction is a branch |
| fetch_ready_o | output | 1 | Fetch buffer can accept this cycle |
| disp_valid_o | output | 1 | An instruction dispatches this cycle |
| disp_tag_o | output | 3 | Ring slot allocated to it |
| disp_branch_o | output | 1 | Dispatched instruction is a branch |
| done_valid_i | input | 1 | Execution finished report |
| done_tag_i | input | 3 | Tag of the finished instruction |
| done_exc_i | input | 1 | Finished instruction raised a fault |
| retire_valid_o | output | 1 | Oldest entry retires this cycle |
| retire_tag_o | output | 3 | Tag of the retiring entry |
| retire_branch_o | output | 1 | Retiring entry is a branch |
| flush_req_o | output | 1 | Flush requested |
| flush_tag_o | output | 3 | Faulting tag of the flush |
| flush_ack_i | input | 1 | Flush acknowledged |

## Verification
Allocation at the tail and release at the head can fall in the same cycle. The bench provokes this with stretches in which no finished reports arrive, so the ring fills to six, and then lets reports in while fetches keep coming. The cycles that both dispatch and retire are then judged against a behavioural model that tracks occupancy by itself. A finished report can also land on an entry in the same cycle that the entry is allocated, or in the same cycle that it faults at the head. The model's rule that a report counts only for an entry that was live at the start of the cycle decides the expected outcome.

// File: rtl/cq_pkg.sv
package cq_pkg;
  typedef struct packed {
    logic live;
    logic fin;
    logic fault;
    logic branch;
  } cq_slot_t;
endpackage

// File: rtl/fetch_buf.sv
module fetch_buf #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic push_i,
  input  logic push_br_i,
  input  logic pop_i,
  input  logic clr_i,
  output logic empty_o,
  output logic full_o,
  output logic head_br_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] br_q, br_d;
  logic [PW-1:0]    rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == CW'(DEPTH));
  assign head_br_o = br_q[rd_q];

  always_comb begin
    br_d  = br_q;
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (clr_i) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_i) begin
        br_d[wr_q] = push_br_i;
        wr_d       = step(wr_q);
      end
      if (pop_i) rd_d = step(rd_q);
      cnt_d = cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      br_q  <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      br_q  <= br_d;
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  // R2
  fq_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    full_o |-> !push_i);
  // R3
  fq_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    empty_o |-> !pop_i);
endmodule

// File: rtl/cq_ring.sv
module cq_ring
  import cq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int TW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          alloc_i,
  input  logic          alloc_br_i,
  input  logic          done_vld_i,
  input  logic [TW-1:0] done_tag_i,
  input  logic          done_exc_i,
  input  logic          retire_i,
  input  logic          flush_i,
  output logic [TW-1:0] head_o,
  output logic [TW-1:0] tail_o,
  output logic          head_ok_o,
  output logic          head_fault_o,
  output logic          head_br_o,
  output logic          full_o
);
  localparam int CW = $clog2(DEPTH + 1);

  cq_slot_t [DEPTH-1:0] slot_q, slot_d;
  logic [TW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [TW-1:0] step(input logic [TW-1:0] p);
    return (p == TW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  cq_slot_t hs;
  assign hs           = slot_q[head_q];
  assign head_o       = head_q;
  assign tail_o       = tail_q;
  assign head_ok_o    = hs.live & hs.fin & ~hs.fault;
  assign head_fault_o = hs.live & hs.fin & hs.fault;
  assign head_br_o    = hs.branch;
  assign full_o       = (cnt_q == CW'(DEPTH));

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_comb begin
      slot_d[i] = slot_q[i];
      if (flush_i) begin
        slot_d[i].live = 1'b0;
      end else if (retire_i && head_q == TW'(i)) begin
        slot_d[i].live = 1'b0;
      end else if (alloc_i && tail_q == TW'(i)) begin
        slot_d[i] = '{live: 1'b1, fin: 1'b0, fault: 1'b0, branch: alloc_br_i};
      end else if (done_vld_i && done_tag_i == TW'(i) && slot_q[i].live) begin
        slot_d[i].fin   = 1'b1;
        slot_d[i].fault = done_exc_i;
      end
    end
  end

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (flush_i) begin
      tail_d = head_q;
      cnt_d  = '0;
    end else begin
      if (retire_i) head_d = step(head_q);
      if (alloc_i)  tail_d = step(tail_q);
      cnt_d = cnt_q + CW'(alloc_i) - CW'(retire_i);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      slot_q <= slot_d;
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  // R4
  full_alloc_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    full_o |-> !alloc_i);
  // R6
  retire_clean_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    retire_i |-> (hs.live && hs.fin && !hs.fault));
  // R10
  occ_balance_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (alloc_i && retire_i && !flush_i) |=> cnt_q == $past(cnt_q));
  // R9
  flush_tail_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    flush_i |=> (tail_q == head_q) && (cnt_q == '0));
endmodule

// File: rtl/flush_ctrl.sv
module flush_ctrl #(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  logic [TW-1:0] trig_tag_i,
  input  logic          ack_i,
  output logic          pend_o,
  output logic [TW-1:0] tag_o
);
  logic          pend_d;
  logic [TW-1:0] tag_d;
  logic          tag_en;

  assign tag_en = trig_i;

  always_comb begin
    pend_d = pend_o;
    tag_d  = tag_o;
    if (trig_i) begin
      pend_d = 1'b1;
    end else if (ack_i) begin
      pend_d = 1'b0;
    end
    if (tag_en) tag_d = trig_tag_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      tag_o  <= '0;
    end else begin
      pend_o <= pend_d;
      tag_o  <= tag_d;
    end
  end

  // R8
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (pend_o && !ack_i) |=> pend_o && $stable(tag_o));
  // R8
  flush_retrig_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    pend_o |-> !trig_i);
endmodule

// File: rtl/ooo_completion_ctrl.sv
module ooo_completion_ctrl #(
  parameter int FQ_DEPTH = 4,
  parameter int CQ_DEPTH = 6,
  parameter int TW       = $clog2(CQ_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid_i,
  input  logic          fetch_branch_i,
  output logic          fetch_ready_o,
  output logic          disp_valid_o,
  output logic [TW-1:0] disp_tag_o,
  output logic          disp_branch_o,
  input  logic          done_valid_i,
  input  logic [TW-1:0] done_tag_i,
  input  logic          done_exc_i,
  output logic          retire_valid_o,
  output logic [TW-1:0] retire_tag_o,
  output logic          retire_branch_o,
  output logic          flush_req_o,
  output logic [TW-1:0] flush_tag_o,
  input  logic          flush_ack_i
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic fq_empty, fq_full, fq_head_br;
  logic cq_full, head_ok, head_fault, head_br;
  logic [TW-1:0] cq_head, cq_tail;
  logic flush_now, do_disp, do_push;

  assign flush_now     = head_fault & ~flush_req_o;
  assign do_disp       = ~fq_empty & ~cq_full & ~flush_now & ~flush_req_o;
  assign fetch_ready_o = ~fq_full & ~flush_now & ~flush_req_o;
  assign do_push       = fetch_valid_i & fetch_ready_o;

  assign disp_valid_o    = do_disp;
  assign disp_tag_o      = cq_tail;
  assign disp_branch_o   = fq_head_br;
  assign retire_valid_o  = head_ok;
  assign retire_tag_o    = cq_head;
  assign retire_branch_o = head_br;

  fetch_buf #(.DEPTH(FQ_DEPTH)) u_fq (
    .clk      (clk),
    .rst_ni   (rst_i_n),
    .push_i   (do_push),
    .push_br_i(fetch_branch_i),
    .pop_i    (do_disp),
    .clr_i    (flush_now),
    .empty_o  (fq_empty),
    .full_o   (fq_full),
    .head_br_o(fq_head_br)
  );

  cq_ring #(.DEPTH(CQ_DEPTH), .TW(TW)) u_cq (
    .clk         (clk),
    .rst_ni      (rst_i_n),
    .alloc_i     (do_disp),
    .alloc_br_i  (fq_head_br),
    .done_vld_i  (done_valid_i),
    .done_tag_i  (done_tag_i),
    .done_exc_i  (done_exc_i),
    .retire_i    (head_ok),
    .flush_i     (flush_now),
    .head_o      (cq_head),
    .tail_o      (cq_tail),
    .head_ok_o   (head_ok),
    .head_fault_o(head_fault),
    .head_br_o   (head_br),
    .full_o      (cq_full)
  );

  flush_ctrl #(.TW(TW)) u_fl (
    .clk       (clk),
    .rst_ni    (rst_i_n),
    .trig_i    (flush_now),
    .trig_tag_i(cq_head),
    .ack_i     (flush_ack_i),
    .pend_o    (flush_req_o),
    .tag_o     (flush_tag_o)
  );

  // R8
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    flush_req_o |-> (!disp_valid_o && !retire_valid_o && !fetch_ready_o));
  // R6
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(retire_valid_o && flush_now));
  // R3
  tag_seq_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (disp_valid_o && disp_tag_o != TW'(CQ_DEPTH - 1)) |=>
      (disp_tag_o == $past(disp_tag_o) + 1'b1) || flush_req_o || $past(flush_now));
endmodule

// File: tb/tb_ooo_completion_ctrl.sv
module tb_ooo_completion_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCYC = 4000;

  logic clk = 1'b0;
  logic rst_n;
  logic fetch_valid_i, fetch_branch_i, fetch_ready_o;
  logic disp_valid_o, disp_branch_o;
  logic [2:0] disp_tag_o;
  logic done_valid_i, done_exc_i;
  logic [2:0] done_tag_i;
  logic retire_valid_o, retire_branch_o;
  logic [2:0] retire_tag_o;
  logic flush_req_o, flush_ack_i;
  logic [2:0] flush_tag_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  ooo_completion_ctrl dut (.*);

  int checks = 0, fails = 0;

  // behavioural model
  bit fq[$];
  bit cv[6], cd[6], ce[6], cb[6];
  int head = 0, tail = 0, cnt = 0, ftag = 0;
  bit fpend = 0;
  int disp_order[$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    fetch_valid_i = 0; fetch_branch_i = 0; done_valid_i = 0;
    done_tag_i = 0; done_exc_i = 0; flush_ack_i = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "disp_valid", disp_valid_o, 0);
    chk("R1", "retire_valid", retire_valid_o, 0);
    chk("R1", "flush_req", flush_req_o, 0);
    chk("R1", "fetch_ready", fetch_ready_o, 1);
    rst_n = 1;
    repeat (4) @(posedge clk);

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      bit f_now, ret, disp, frdy, exc_on, dv;
      int dprob, tg;
      @(negedge clk);
      // phases: clean, starved (ring fills), faulty
      exc_on = (cyc >= 1500);
      dprob  = ((cyc >= 800 && cyc < 1000) || (cyc % 300 < 40)) ? 0 : 55;
      fetch_valid_i  = ($urandom_range(99) < 75);
      fetch_branch_i = $urandom_range(1);
      done_valid_i   = ($urandom_range(99) < dprob);
      done_tag_i     = 3'($urandom_range(7));
      done_exc_i     = exc_on && ($urandom_range(9) == 0);
      flush_ack_i    = ($urandom_range(3) == 0);
      #1;
      f_now = cv[head] && cd[head] && ce[head] && !fpend;
      ret   = cv[head] && cd[head] && !ce[head];
      disp  = (fq.size() > 0) && (cnt < 6) && !f_now && !fpend;
      frdy  = (fq.size() < 4) && !fpend && !f_now;
      // R2 R8 fetch acceptance
      chk("R2", "fetch_ready", fetch_ready_o, frdy);
      // R3 R4 R8 dispatch gating
      chk("R4", "disp_valid", disp_valid_o, disp);
      if (disp) begin
        // R3 R9 tag order, R5 branch flag
        chk("R3", "disp_tag", disp_tag_o, tail);
        chk("R5", "disp_branch", disp_branch_o, fq[0]);
      end
      // R6 in-order retire
      chk("R6", "retire_valid", retire_valid_o, ret);
      if (ret) begin
        chk("R6", "retire_tag", retire_tag_o, head);
        chk("R6", "retire_order", retire_tag_o, disp_order.size() ? disp_order[0] : -1);
        chk("R5", "retire_branch", retire_branch_o, cb[head]);
      end
      // R8 flush request
      chk("R8", "flush_req", flush_req_o, fpend);
      if (fpend) chk("R8", "flush_tag", flush_tag_o, ftag);

      // model update for the coming edge
      dv = done_valid_i;
      tg = done_tag_i;
      if (f_now) begin
        for (int i = 0; i < 6; i++) cv[i] = 0;
        tail = head; cnt = 0; fq.delete(); disp_order.delete();
        fpend = 1; ftag = head;
      end else begin
        // R7 reports count only for live entries
        if (dv && tg < 6 && cv[tg]) begin cd[tg] = 1; ce[tg] = done_exc_i; end
        if (ret) begin
          cv[head] = 0; head = (head + 1) % 6; cnt--;
          void'(disp_order.pop_front());
        end
        if (disp) begin
          cv[tail] = 1; cd[tail] = 0; ce[tail] = 0; cb[tail] = fq.pop_front();
          disp_order.push_back(tail);
          tail = (tail + 1) % 6; cnt++;
        end
        if (fpend && flush_ack_i) fpend = 0;
        if (fetch_valid_i && frdy) fq.push_back(fetch_branch_i);
      end
    end
    fetch_valid_i = 0; done_valid_i = 0; flush_ack_i = 0;
    finish_run();
  end
endmodule